// File: doc/BRIEF.md
# Branch and Jump Target Resolver

This block takes one control-flow instruction per cycle and decides where execution goes next. Alongside the 32-bit instruction word it receives the address of that instruction, the 64-bit contents of the integer register named by the instruction, and two flags describing a floating-point operand (negative, zero). One clock later it reports four things:

- whether the transfer is taken;
- the resolved next fetch address;
- whether a return address must be written;
- which register receives that address, and the address itself.

Three groups of instruction are resolved:

- **PC-relative branches.** These carry a 21-bit signed word displacement measured from the following instruction. This group covers the unconditional branch, branch-to-subroutine, eight integer conditional branches and six floating conditional branches.
- **Register-indirect jump.** One opcode, whose 2-bit hint field tells jump, call and return apart for other logic. The hint does not affect resolution here.
- **Everything else.** Any other opcode falls through to the next sequential address.

The pipeline stage that owns the program counter uses the block. The next fetch address can feed the fetch redirect directly. The link port can feed a register-file write port.

Top module: `bjr_resolver`

## Requirements
- R1: For opcodes 0x30..0x3F, the branch destination is (pc + 4) + 4 × sext(instr[20:0]), computed modulo 2^64. This covers displacements that go backwards and displacements that wrap the address space.
- R2: Opcodes 0x30 and 0x34 are always taken, and both request a link write to the register in instr[25:21].
- R3: Integer conditional branches test src_val as a signed 64-bit value:
  - 0x39 is taken when the value equals zero; 0x3D when it is nonzero.
  - 0x3A is taken when the value is less than zero; 0x3E when it is greater than or equal to zero.
  - 0x3B is taken when the value is less than or equal to zero; 0x3F when it is greater than zero.
- R4: Opcode 0x38 is taken when src_val bit 0 is 0, and opcode 0x3C is taken when src_val bit 0 is 1. The other bits of src_val have no effect on either.
- R5: Floating conditional branches use only the two flags, and fp_zero set means the value is zero whatever fp_neg says:
  - 0x31 is taken when the value is zero; 0x35 when it is nonzero.
  - 0x32 is taken when the value is less than zero; 0x36 when it is greater than or equal to zero.
  - 0x33 is taken when the value is less than or equal to zero; 0x37 when it is greater than zero.
- R6: Opcode 0x1A is always taken. Its destination is src_val with bits [1:0] forced to zero, and it requests a link write to the register in instr[25:21].
- R7: link_val is pc + 4 and link_reg is instr[25:21] for every accepted instruction. link_we is 1 only when a link write was requested and instr[25:21] is not 31.
- R8: When an instruction is not taken, taken is 0 and tgt_addr is pc + 4. Any opcode outside R1..R6 is never taken and never writes a link.
- R9: Results appear exactly one clock after in_valid is sampled high, with out_valid = 1, and out_valid is 0 otherwise. While rst_n is low, every output is 0.
- R10: The hint field instr[15:14] of opcode 0x1A has no effect on taken, tgt_addr or the link outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction fields below are valid this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| src_val | input | 64 | Tested register value, or jump base value |
| fp_neg | input | 1 | Floating operand sign is negative |
| fp_zero | input | 1 | Floating operand is zero |
| out_valid | output | 1 | Result of the instruction accepted last cycle |
| taken | output | 1 | Control transfer taken |
| tgt_addr | output | 64 | Resolved next fetch address |
| link_we | output | 1 | Write link_val to link_reg |
| link_reg | output | 5 | Destination register index |
| link_val | output | 64 | Return address (pc + 4) |

## Verification
The following properties are checked in every cycle:
- the one-cycle valid latency;
- the link value tracking pc + 4;
- the ban on link writes to register 31;
- the fall-through rule that a not-taken result points at pc + 4;
- word alignment of every register-jump destination.

Only the bench scenarios can show:
- that each of the fourteen conditions picks the correct outcome for zero, negative, positive, odd and negative-zero operands;
- that displacement arithmetic wraps correctly in both directions;
- that the jump hint is ignored.

// File: rtl/bjr_pkg.sv
package bjr_pkg;

   typedef enum logic [2:0] {
      CF_NONE   = 3'd0,
      CF_UNCOND = 3'd1,
      CF_ICOND  = 3'd2,
      CF_FCOND  = 3'd3,
      CF_JUMP   = 3'd4
   } cf_class_e;

   localparam int OPC_W = 6;
   localparam int REG_W = 5;

   localparam logic [OPC_W-1:0] OPC_RJUMP  = 6'h1A;
   localparam logic [OPC_W-1:0] OPC_BRANCH = 6'h30;
   localparam logic [OPC_W-1:0] OPC_BSUB   = 6'h34;
   localparam logic [REG_W-1:0] ZERO_REG   = 5'd31;

endpackage

// File: rtl/bjr_decode.sv
module bjr_decode
   import bjr_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int DISP_W  = 21
) (
   input  logic [INSTR_W-1:0] instr,
   output cf_class_e          cls,
   output logic [REG_W-1:0]   ra,
   output logic [2:0]         cond_sel,
   output logic [DISP_W-1:0]  disp
);
   localparam int OPC_LSB = INSTR_W - OPC_W;
   localparam int RA_LSB  = OPC_LSB - REG_W;

   logic [OPC_W-1:0] opc;

   generate
      if (INSTR_W != 32) begin : g_bad_instr
         initial $error("bjr_decode: INSTR_W must be 32");
      end
      if (DISP_W > RA_LSB) begin : g_bad_disp
         initial $error("bjr_decode: displacement overlaps register field");
      end
   endgenerate

   assign opc      = instr[INSTR_W-1:OPC_LSB];
   assign ra       = instr[RA_LSB +: REG_W];
   assign disp     = instr[DISP_W-1:0];
   assign cond_sel = opc[2:0];

   always_comb begin
      cls = CF_NONE;
      if (opc == OPC_RJUMP) begin
         cls = CF_JUMP;
      end else if (opc[5:3] == 3'b111) begin
         cls = CF_ICOND;
      end else if (opc[5:3] == 3'b110) begin
         if (opc == OPC_BRANCH || opc == OPC_BSUB) cls = CF_UNCOND;
         else                                      cls = CF_FCOND;
      end
   end

endmodule

// File: rtl/bjr_cond.sv
module bjr_cond #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] src_val,
   input  logic              fp_neg,
   input  logic              fp_zero,
   input  logic              use_fp,
   input  logic [2:0]        sel,
   output logic              hit
);
   localparam int N_BASE = 4;

   logic              is_zero;
   logic              is_neg;
   logic [N_BASE-1:0] int_base;
   logic [N_BASE-1:0] fp_base;
   logic [N_BASE-1:0] base;

   assign is_zero = (src_val == '0);
   assign is_neg  = src_val[DATA_W-1];

   // base tests: 0 low bit clear, 1 zero, 2 negative, 3 negative or zero
   assign int_base = {is_neg | is_zero, is_neg, is_zero, ~src_val[0]};
   assign fp_base  = {fp_neg | fp_zero, fp_neg & ~fp_zero, fp_zero, 1'b0};

   generate
      for (genvar gi = 0; gi < N_BASE; gi++) begin : g_base
         assign base[gi] = use_fp ? fp_base[gi] : int_base[gi];
      end
   endgenerate

   // sel[2] selects the complementary condition
   assign hit = base[sel[1:0]] ^ sel[2];

endmodule

// File: rtl/bjr_target.sv
module bjr_target #(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64,
   parameter int DISP_W = 21
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] src_val,
   input  logic [DISP_W-1:0] disp,
   input  logic              is_jump,
   output logic [ADDR_W-1:0] seq_pc,
   output logic [ADDR_W-1:0] dest
);
   localparam int          EXT_W      = ADDR_W - DISP_W - 2;
   localparam [ADDR_W-1:0] INSTR_BYTES = ADDR_W'(4);
   localparam [ADDR_W-1:0] ALIGN_MASK  = ADDR_W'(3);

   logic [ADDR_W-1:0] byte_off;
   logic [ADDR_W-1:0] jump_base;

   generate
      if (EXT_W < 1) begin : g_bad_w
         initial $error("bjr_target: ADDR_W too small for displacement");
      end
      if (DATA_W != ADDR_W) begin : g_bad_dw
         initial $error("bjr_target: DATA_W must equal ADDR_W");
      end
   endgenerate

   assign seq_pc    = pc + INSTR_BYTES;
   assign byte_off  = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
   assign jump_base = src_val[ADDR_W-1:0] & ~ALIGN_MASK;
   assign dest      = is_jump ? jump_base : (seq_pc + byte_off);

endmodule

// File: rtl/bjr_resolver.sv
module bjr_resolver
   import bjr_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int ADDR_W  = 64,
   parameter int DATA_W  = 64,
   parameter int DISP_W  = 21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [INSTR_W-1:0] instr,
   input  logic [ADDR_W-1:0]  pc,
   input  logic [DATA_W-1:0]  src_val,
   input  logic               fp_neg,
   input  logic               fp_zero,
   output logic               out_valid,
   output logic               taken,
   output logic [ADDR_W-1:0]  tgt_addr,
   output logic               link_we,
   output logic [REG_W-1:0]   link_reg,
   output logic [ADDR_W-1:0]  link_val
);
   cf_class_e          cls;
   logic [REG_W-1:0]   ra;
   logic [2:0]         cond_sel;
   logic [DISP_W-1:0]  disp;
   logic               cond_hit;
   logic [ADDR_W-1:0]  seq_pc;
   logic [ADDR_W-1:0]  dest;
   logic               take_c;
   logic               link_req;
   logic [ADDR_W-1:0]  next_c;

   bjr_decode #(.INSTR_W(INSTR_W), .DISP_W(DISP_W)) u_dec (
      .instr(instr), .cls(cls), .ra(ra), .cond_sel(cond_sel), .disp(disp)
   );

   bjr_cond #(.DATA_W(DATA_W)) u_cond (
      .src_val(src_val), .fp_neg(fp_neg), .fp_zero(fp_zero),
      .use_fp(cls == CF_FCOND), .sel(cond_sel), .hit(cond_hit)
   );

   bjr_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DISP_W(DISP_W)) u_tgt (
      .pc(pc), .src_val(src_val), .disp(disp), .is_jump(cls == CF_JUMP),
      .seq_pc(seq_pc), .dest(dest)
   );

   always_comb begin
      take_c   = 1'b0;
      link_req = 1'b0;
      unique case (cls)
         CF_UNCOND, CF_JUMP: begin
            take_c   = 1'b1;
            link_req = 1'b1;
         end
         CF_ICOND, CF_FCOND: take_c = cond_hit;
         default: ;
      endcase
      next_c = take_c ? dest : seq_pc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         taken     <= 1'b0;
         tgt_addr  <= '0;
         link_we   <= 1'b0;
         link_reg  <= '0;
         link_val  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            taken    <= take_c;
            tgt_addr <= next_c;
            link_we  <= link_req && (ra != ZERO_REG);
            link_reg <= ra;
            link_val <= seq_pc;
         end else begin
            taken   <= 1'b0;
            link_we <= 1'b0;
         end
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid) else $error("valid latency");            // R9
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !link_we) else $error("spurious out"); // R9
   AST_LINK_PC4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> link_val == $past(pc) + ADDR_W'(4)) else $error("link value"); // R7
   AST_NO_R31_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> link_reg != ZERO_REG) else $error("r31 link");       // R7
   AST_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !taken |-> tgt_addr == link_val) else $error("fallthrough"); // R8
   AST_JUMP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && instr[INSTR_W-1 -: OPC_W] == OPC_RJUMP |=> taken && tgt_addr[1:0] == 2'b00)
      else $error("jump align");                                       // R6

endmodule

// File: tb/tb_bjr_resolver.sv
`timescale 1ns/1ps
module tb_bjr_resolver;

   typedef struct packed {
      logic        tk;
      logic [63:0] tgt;
      logic        lwe;
      logic [4:0]  lreg;
      logic [63:0] lval;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [63:0] pc = '0;
   logic [63:0] src_val = '0;
   logic        fp_neg = 1'b0;
   logic        fp_zero = 1'b0;
   logic        out_valid, taken, link_we;
   logic [63:0] tgt_addr, link_val;
   logic [4:0]  link_reg;

   int total = 0;
   int bad = 0;
   int pushed = 0;
   int popped = 0;
   bit finished = 0;
   exp_t  exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   bjr_resolver dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
      .src_val(src_val), .fp_neg(fp_neg), .fp_zero(fp_zero),
      .out_valid(out_valid), .taken(taken), .tgt_addr(tgt_addr),
      .link_we(link_we), .link_reg(link_reg), .link_val(link_val)
   );

   function automatic exp_t model(input logic [31:0] ins, input logic [63:0] p,
                                  input logic [63:0] v, input logic n, input logic z);
      exp_t e;
      logic tk, lk;
      logic [63:0] seq, bt, dst;
      logic [5:0] op;
      op  = ins[31:26];
      seq = p + 64'd4;
      bt  = seq + {{41{ins[20]}}, ins[20:0], 2'b00};
      dst = bt;
      tk  = 1'b0;
      lk  = 1'b0;
      case (op)
         6'h30, 6'h34: begin tk = 1; lk = 1; end
         6'h38: tk = !v[0];
         6'h3C: tk = v[0];
         6'h39: tk = (v == 0);
         6'h3D: tk = (v != 0);
         6'h3A: tk = ($signed(v) < 0);
         6'h3B: tk = ($signed(v) <= 0);
         6'h3E: tk = ($signed(v) >= 0);
         6'h3F: tk = ($signed(v) > 0);
         6'h31: tk = z;
         6'h35: tk = !z;
         6'h32: tk = n && !z;
         6'h33: tk = n || z;
         6'h36: tk = !n || z;
         6'h37: tk = !n && !z;
         6'h1A: begin tk = 1; lk = 1; dst = {v[63:2], 2'b00}; end
         default: ;
      endcase
      e.tk   = tk;
      e.tgt  = tk ? dst : seq;
      e.lwe  = lk && (ins[25:21] != 5'd31);
      e.lreg = ins[25:21];
      e.lval = seq;
      return e;
   endfunction

   function automatic logic [31:0] mk_br(input logic [5:0] op, input logic [4:0] ra,
                                         input int d);
      logic [20:0] dd;
      dd = 21'(d);
      return {op, ra, dd};
   endfunction

   function automatic logic [31:0] mk_jmp(input logic [4:0] ra, input logic [1:0] hint);
      return {6'h1A, ra, 5'd27, hint, 14'h0123};
   endfunction

   task automatic send(input logic [31:0] ins, input logic [63:0] p, input logic [63:0] v,
                       input logic n, input logic z, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      instr    = ins;
      pc       = p;
      src_val  = v;
      fp_neg   = n;
      fp_zero  = z;
      exp_q.push_back(model(ins, p, v, n, z));
      tag_q.push_back(tag);
      pushed++;
   endtask

   task automatic idle(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         instr    = 32'hFFFF_FFFF;
         src_val  = 64'hDEAD;
      end
   endtask

   // monitor: sample one time unit after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && out_valid) begin
            exp_t  e;
            string t;
            total++;
            if (exp_q.size() == 0) begin
               bad++;
               $display("FAIL R9: out_valid with nothing expected (actual 1, expected 0)");
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               popped++;
               if (taken !== e.tk || tgt_addr !== e.tgt || link_we !== e.lwe ||
                   link_reg !== e.lreg || link_val !== e.lval) begin
                  bad++;
                  $display("FAIL %s: actual tk=%0b tgt=%h lwe=%0b lreg=%0d lval=%h expected tk=%0b tgt=%h lwe=%0b lreg=%0d lval=%h",
                           t, taken, tgt_addr, link_we, link_reg, link_val,
                           e.tk, e.tgt, e.lwe, e.lreg, e.lval);
               end
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // reset state, R9
      repeat (3) @(negedge clk);
      in_valid = 1'b1;
      instr    = mk_br(6'h30, 5'd26, 5);
      @(negedge clk);
      total++;
      if (out_valid !== 0 || taken !== 0 || tgt_addr !== 0 || link_we !== 0 ||
          link_reg !== 0 || link_val !== 0) begin
         bad++;
         $display("FAIL R9: reset outputs actual v=%0b tk=%0b tgt=%h lwe=%0b expected all zero",
                  out_valid, taken, tgt_addr, link_we);
      end
      in_valid = 1'b0;
      rst_n    = 1'b1;
      idle(2);

      // R1 / R2: unconditional forms, forward, backward, wrap, extremes
      send(mk_br(6'h30, 5'd26, 16), 64'h1000, 64'h0, 0, 0, "R2 BR link r26");
      send(mk_br(6'h34, 5'd31, -8), 64'h10, 64'h0, 0, 0, "R1 BSR wrap back, R7 r31");
      send(mk_br(6'h30, 5'd1, 1048575), 64'h4000_0000, 64'h0, 0, 0, "R1 max forward");
      send(mk_br(6'h34, 5'd2, -1048576), 64'h0000_0001_0000_0000, 64'h0, 0, 0, "R1 max backward");
      send(mk_br(6'h30, 5'd3, 1), 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 0, 0, "R1 wrap forward");

      // R3: signed compares
      send(mk_br(6'h39, 5'd4, 10), 64'h200, 64'h0, 0, 0, "R3 EQ zero");
      send(mk_br(6'h39, 5'd4, 10), 64'h200, 64'h5, 0, 0, "R3 EQ nonzero");
      send(mk_br(6'h3D, 5'd4, -3), 64'h200, 64'h5, 0, 0, "R3 NE nonzero");
      send(mk_br(6'h3D, 5'd4, -3), 64'h200, 64'h0, 0, 0, "R3 NE zero");
      send(mk_br(6'h3A, 5'd5, 7), 64'h300, 64'h8000_0000_0000_0000, 0, 0, "R3 LT min");
      send(mk_br(6'h3A, 5'd5, 7), 64'h300, 64'h0, 0, 0, "R3 LT zero");
      send(mk_br(6'h3B, 5'd5, 7), 64'h300, 64'h0, 0, 0, "R3 LE zero");
      send(mk_br(6'h3B, 5'd5, 7), 64'h300, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, "R3 LE max");
      send(mk_br(6'h3E, 5'd6, 2), 64'h400, 64'h0, 0, 0, "R3 GE zero");
      send(mk_br(6'h3E, 5'd6, 2), 64'h400, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R3 GE minus one");
      send(mk_br(6'h3F, 5'd6, 2), 64'h400, 64'h0, 0, 0, "R3 GT zero");
      send(mk_br(6'h3F, 5'd6, 2), 64'h400, 64'h1, 0, 0, "R3 GT one");

      // R4: low-bit tests, upper bits irrelevant
      send(mk_br(6'h38, 5'd7, 4), 64'h500, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, "R4 LBC even");
      send(mk_br(6'h38, 5'd7, 4), 64'h500, 64'h1, 0, 0, "R4 LBC odd");
      send(mk_br(6'h3C, 5'd7, 4), 64'h500, 64'h8000_0000_0000_0001, 0, 0, "R4 LBS odd");
      send(mk_br(6'h3C, 5'd7, 4), 64'h500, 64'h0, 0, 0, "R4 LBS zero");

      // R5: floating flags, negative zero counts as zero
      send(mk_br(6'h31, 5'd8, 9), 64'h600, 64'h1, 1, 1, "R5 FEQ neg zero");
      send(mk_br(6'h35, 5'd8, 9), 64'h600, 64'h0, 1, 1, "R5 FNE neg zero");
      send(mk_br(6'h32, 5'd8, 9), 64'h600, 64'h0, 1, 1, "R5 FLT neg zero");
      send(mk_br(6'h32, 5'd8, 9), 64'h600, 64'h0, 1, 0, "R5 FLT negative");
      send(mk_br(6'h33, 5'd8, 9), 64'h600, 64'h0, 0, 0, "R5 FLE positive");
      send(mk_br(6'h36, 5'd8, 9), 64'h600, 64'h0, 1, 1, "R5 FGE neg zero");
      send(mk_br(6'h37, 5'd8, 9), 64'h600, 64'h0, 0, 0, "R5 FGT positive");
      send(mk_br(6'h37, 5'd8, 9), 64'h600, 64'h0, 0, 1, "R5 FGT zero");

      // R6 / R10: register jump with every hint
      for (int h = 0; h < 4; h++)
         send(mk_jmp(5'd26, 2'(h)), 64'h700, 64'h0000_1234_5678_9ABF, 0, 0, "R10 hint jump");
      send(mk_jmp(5'd31, 2'd2), 64'h800, 64'hFFFF_FFFF_FFFF_FFFD, 0, 0, "R6 return r31");

      // R8: non-control opcodes
      send(32'h4000_0000 | mk_br(6'h10, 5'd9, 100), 64'h900, 64'h0, 1, 1, "R8 operate opcode");
      send(mk_br(6'h1B, 5'd9, 100), 64'h904, 64'h0, 1, 1, "R8 near jump opcode");

      // R9: gap then back-to-back
      idle(3);
      send(mk_br(6'h39, 5'd10, -1), 64'hA00, 64'h0, 0, 0, "R9 after gap");
      send(mk_br(6'h30, 5'd0, 0), 64'hA04, 64'h0, 0, 0, "R7 r0 link");
      idle(4);

      total++;
      if (pushed != popped || exp_q.size() != 0) begin
         bad++;
         $display("FAIL R9: results actual=%0d expected=%0d", popped, pushed);
      end
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule